// File: doc/BRIEF.md
# Trimmed one-second divider with BCD seconds

This block turns a 32.768 kHz oscillator clock into a one-second tick and corrects timekeeping in digital logic. The oscillator itself is never retuned. Only the count that makes up certain seconds is changed. A host writes a signed 7-bit trim code. Once in every twenty seconds, the divide count for one second is lengthened or shortened by an even number of oscillator cycles derived from that code. Each two-cycle step per twenty seconds shifts the counted time by about 3.05 ppm, which gives a correction resolution of roughly ±1.5 ppm.

The block also keeps the seconds of the time of day as a BCD count from 00 to 59. That count decides which seconds get trimmed: only the seconds that read 00, 20 and 40. The count for each second is fixed at the first cycle of that second. A trim code written while a second is running therefore affects only a later trimmed second.

The parameter `NOMINAL_CNT` sets the untrimmed length of a second. It defaults to 32768 and must be larger than 129 so that the largest decrement still leaves a second of at least two cycles.

Top module: `tick_trim_divider`

## Requirements
- R1: While `rst` is high at a rising edge, the block clears `sec_tick` to 0, `sec_bcd` to 8'h00 and the trim code to 7'b0000000. The first second after reset lasts `NOMINAL_CNT` cycles.
- R2: Every second whose `sec_bcd` value is not 00, 20 or 40 lasts exactly `NOMINAL_CNT` cycles, whatever the trim code is.
- R3: For a trim code F with F[6]=0 and F ≥ 2, a trimmed second lasts `NOMINAL_CNT + 2*(F-1)` cycles. For example, code 7'h07 adds 12 cycles and code 7'h3F adds 124 cycles.
- R4: Trim codes 7'h00 and 7'h01 leave a trimmed second at `NOMINAL_CNT` cycles.
- R5: For a trim code with F[6]=1, a trimmed second lasts `NOMINAL_CNT - 2*M` cycles, where M = (~F[5:0]) + 1 taken as a 7-bit value. For example, code 7'h7E removes 4 cycles.
- R6: Code 7'h40 gives the largest decrement, so a trimmed second lasts `NOMINAL_CNT - 128` cycles.
- R7: The length of a second is fixed from the trim code held at the edge where that second begins. A write during a second, including a write at the same edge that ends the previous second, changes only later trimmed seconds. The trim register captures `trim_din` on every rising edge with `trim_we` high.
- R8: `sec_bcd` holds the tens digit (0..5) in bits [6:4] and the units digit (0..9) in bits [3:0], with bit 7 at 0. It counts 00 to 59 and then wraps to 00.
- R9: `sec_tick` is high for exactly one cycle, the last cycle of each second. `sec_bcd` advances on the edge that ends that cycle and stays constant at every other edge.
- R10: Only the seconds that read 00, 20 and 40 are trimmed. For example, second 10 keeps `NOMINAL_CNT` cycles even with a nonzero code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator-rate clock, one cycle per count |
| rst | input | 1 | Synchronous active-high reset |
| trim_we | input | 1 | Host write strobe for the trim code |
| trim_din | input | 7 | Signed trim code written by the host |
| sec_tick | output | 1 | One-cycle pulse in the last cycle of each second |
| sec_bcd | output | 8 | Seconds of the time of day in BCD |

## Verification
A host write to the trim register can land on the same edge that closes a second, just before a trimmed second starts. The bench provokes this by raising `trim_we` in the cycle where `sec_tick` is high at second 39. It then expects second 40 to use the code that was held before that edge, and second 00 to use the new code. The other same-cycle case is the end of second 59. There the BCD wrap and the choice of a trimmed length for second 00 fall on one edge, and the bench checks both the wrapped value and the length of the wrapped second.

// File: rtl/rtc_trim_pkg.sv
package rtc_trim_pkg;

    typedef struct packed {
        logic [2:0] tens;
        logic [3:0] units;
    } bcd_sec_t;

    localparam int TRIM_W    = 7;
    localparam int MAX_GROW  = 124;
    localparam int MAX_SHRINK = 128;

    // Signed cycle adjustment for a trimmed second.
    function automatic int trim_delta(input logic [TRIM_W-1:0] code);
        logic [TRIM_W-1:0] mag;
        int d;
        if (!code[TRIM_W-1]) begin
            if (code <= 7'd1) d = 0;
            else              d = 2 * (int'(code) - 1);
        end else begin
            mag = {1'b0, ~code[TRIM_W-2:0]} + 7'd1;
            d   = -2 * int'(mag);
        end
        return d;
    endfunction

    // Seconds that carry the trim: 00, 20, 40.
    function automatic logic is_trim_sec(input bcd_sec_t s);
        return (s.units == 4'd0) &&
               ((s.tens == 3'd0) || (s.tens == 3'd2) || (s.tens == 3'd4));
    endfunction

    function automatic bcd_sec_t bcd_step(input bcd_sec_t s);
        bcd_sec_t n;
        if (s.units == 4'd9) begin
            n.units = 4'd0;
            n.tens  = (s.tens == 3'd5) ? 3'd0 : s.tens + 3'd1;
        end else begin
            n.units = s.units + 4'd1;
            n.tens  = s.tens;
        end
        return n;
    endfunction

endpackage

// File: rtl/trim_code_reg.sv
module trim_code_reg
    import rtc_trim_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [TRIM_W-1:0] din,
    output logic [TRIM_W-1:0] code
);
    always_ff @(posedge clk) begin
        if (rst)     code <= '0;
        else if (we) code <= din;
    end
endmodule

// File: rtl/bcd_second_ctr.sv
module bcd_second_ctr
    import rtc_trim_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     adv,
    output bcd_sec_t sec,
    output bcd_sec_t sec_nxt
);
    assign sec_nxt = bcd_step(sec);

    always_ff @(posedge clk) begin
        if (rst)      sec <= '0;
        else if (adv) sec <= sec_nxt;
    end
endmodule

// File: rtl/trim_len_divider.sv
module trim_len_divider
    import rtc_trim_pkg::*;
#(
    parameter int NOMINAL_CNT = 32768
)(
    input  logic              clk,
    input  logic              rst,
    input  logic [TRIM_W-1:0] code,
    input  bcd_sec_t          sec_nxt,
    output logic              tick
);
    localparam int MAX_LEN = NOMINAL_CNT + MAX_GROW;
    localparam int CW      = $clog2(MAX_LEN + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] len_q;
    logic [CW-1:0] len_d;

    always_comb begin
        int l;
        l = NOMINAL_CNT;
        if (is_trim_sec(sec_nxt)) l = l + trim_delta(code);
        len_d = CW'(l);
    end

    assign tick = (cnt == (len_q - CW'(1)));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            len_q <= CW'(NOMINAL_CNT);
        end else if (tick) begin
            cnt   <= '0;
            len_q <= len_d;
        end else begin
            cnt   <= cnt + CW'(1);
        end
    end
endmodule

// File: rtl/tick_trim_divider.sv
module tick_trim_divider
    import rtc_trim_pkg::*;
#(
    parameter int NOMINAL_CNT = 32768
)(
    input  logic       clk,
    input  logic       rst,
    input  logic       trim_we,
    input  logic [6:0] trim_din,
    output logic       sec_tick,
    output logic [7:0] sec_bcd
);
    logic [TRIM_W-1:0] code;
    bcd_sec_t          sec;
    bcd_sec_t          sec_nxt;

    trim_code_reg u_code (
        .clk  (clk),
        .rst  (rst),
        .we   (trim_we),
        .din  (trim_din),
        .code (code)
    );

    bcd_second_ctr u_sec (
        .clk     (clk),
        .rst     (rst),
        .adv     (sec_tick),
        .sec     (sec),
        .sec_nxt (sec_nxt)
    );

    trim_len_divider #(.NOMINAL_CNT(NOMINAL_CNT)) u_div (
        .clk     (clk),
        .rst     (rst),
        .code    (code),
        .sec_nxt (sec_nxt),
        .tick    (sec_tick)
    );

    assign sec_bcd = {1'b0, sec};
endmodule

// File: rtl/trim_divider_chk.sv
module trim_divider_chk #(
    parameter int NOMINAL_CNT = 32768
)(
    input logic       clk,
    input logic       rst,
    input logic       sec_tick,
    input logic [7:0] sec_bcd
);
    int gap;

    always_ff @(posedge clk) begin
        if (rst)           gap <= 0;
        else if (sec_tick) gap <= 0;
        else               gap <= gap + 1;
    end

    logic trimmed_now;
    assign trimmed_now = (sec_bcd == 8'h00) || (sec_bcd == 8'h20) || (sec_bcd == 8'h40);

    // R9
    tick_single_chk: assert property (@(posedge clk) disable iff (rst)
        sec_tick |=> !sec_tick);

    // R9
    sec_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !sec_tick |=> $stable(sec_bcd));

    // R8
    bcd_range_chk: assert property (@(posedge clk) disable iff (rst)
        (sec_bcd[7] == 1'b0) && (sec_bcd[3:0] <= 4'd9) && (sec_bcd[6:4] <= 3'd5));

    // R8
    wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (sec_tick && sec_bcd == 8'h59) |=> (sec_bcd == 8'h00));

    // R2
    plain_len_chk: assert property (@(posedge clk) disable iff (rst)
        (sec_tick && !trimmed_now) |-> (gap == NOMINAL_CNT - 1));

    // R3
    len_bound_chk: assert property (@(posedge clk) disable iff (rst)
        gap <= NOMINAL_CNT + 123);
endmodule

bind tick_trim_divider trim_divider_chk #(.NOMINAL_CNT(NOMINAL_CNT)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .sec_tick (sec_tick),
    .sec_bcd  (sec_bcd)
);

// File: tb/tick_trim_divider_test.sv
module tick_trim_divider_test;
    localparam int NOM = 200;

    logic       clk = 0;
    logic       rst = 1;
    logic       trim_we = 0;
    logic [6:0] trim_din = '0;
    logic       sec_tick;
    logic [7:0] sec_bcd;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    string cur_req = "R1";

    // reference model state
    int m_sec = 0, m_cyc = 0, m_len = NOM, m_code = 0;

    always #2.5 clk = ~clk;

    tick_trim_divider #(.NOMINAL_CNT(NOM)) uut (
        .clk(clk), .rst(rst), .trim_we(trim_we), .trim_din(trim_din),
        .sec_tick(sec_tick), .sec_bcd(sec_bcd)
    );

    function automatic int ref_adj(input int c);
        if (c >= 64)     return -2 * (128 - c);
        else if (c <= 1) return 0;
        else             return 2 * (c - 1);
    endfunction

    function automatic logic [7:0] to_bcd(input int s);
        return 8'((s / 10) * 16 + (s % 10));
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_sec = 0; m_cyc = 0; m_len = NOM; m_code = 0;
        end else begin
            if (m_cyc == m_len - 1) begin
                m_cyc = 0;
                m_sec = (m_sec + 1) % 60;
                m_len = (m_sec % 20 == 0) ? NOM + ref_adj(m_code) : NOM;
            end else begin
                m_cyc = m_cyc + 1;
            end
            if (trim_we) m_code = int'(trim_din);
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // per-cycle comparison with the model
    always @(negedge clk) begin
        if (!rst) begin
            check(cur_req, "tick vs model", int'(sec_tick), int'(m_cyc == m_len - 1));
            check(cur_req, "seconds vs model", int'(sec_bcd), int'(to_bcd(m_sec)));
        end
    end

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles == 150000) begin
            fails++;
            $display("FAIL R9 watchdog expired actual=%0d expected=0", cycles);
            summary();
        end
    end

    task automatic set_code(input logic [6:0] c);
        @(negedge clk);
        trim_we = 1; trim_din = c;
        @(negedge clk);
        trim_we = 0;
    endtask

    // stop at the first cycle of the given second
    task automatic go_to_sec(input logic [7:0] target);
        logic was;
        was = sec_tick;
        forever begin
            @(negedge clk);
            if (was && sec_bcd == target) break;
            was = sec_tick;
        end
    endtask

    task automatic measure(output int n);
        n = 1;
        while (!sec_tick) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        int n;
        repeat (4) @(negedge clk);
        check("R1", "tick in reset", int'(sec_tick), 0);
        check("R1", "seconds in reset", int'(sec_bcd), 0);
        rst = 0;
        // R1: first second after reset
        measure(n);
        check("R1", "length of first second", n, NOM);

        cur_req = "R3";
        set_code(7'h07);
        go_to_sec(8'h20); measure(n);
        check("R3", "code 07 second 20", n, NOM + 12);
        cur_req = "R2";
        go_to_sec(8'h21); measure(n);
        check("R2", "second 21 untrimmed", n, NOM);

        cur_req = "R4";
        set_code(7'h01);
        go_to_sec(8'h40); measure(n);
        check("R4", "code 01 second 40", n, NOM);

        cur_req = "R5";
        set_code(7'h7E);
        go_to_sec(8'h00); measure(n);
        check("R5", "code 7E second 00", n, NOM - 4);

        cur_req = "R6";
        set_code(7'h40);
        go_to_sec(8'h20); measure(n);
        check("R6", "code 40 second 20", n, NOM - 128);

        cur_req = "R3";
        set_code(7'h3F);
        go_to_sec(8'h40); measure(n);
        check("R3", "code 3F second 40", n, NOM + 124);

        // R7: write in the middle of a trimmed second
        cur_req = "R7";
        set_code(7'h00);
        go_to_sec(8'h00);
        n = 1;
        repeat (50) begin @(negedge clk); n++; end
        trim_we = 1; trim_din = 7'h07;
        @(negedge clk); n++;
        trim_we = 0;
        while (!sec_tick) begin @(negedge clk); n++; end
        check("R7", "mid-second write ignored", n, NOM);
        go_to_sec(8'h20); measure(n);
        check("R7", "new code at next trimmed second", n, NOM + 12);

        // R7: write on the edge that closes second 39
        go_to_sec(8'h39);
        while (!sec_tick) @(negedge clk);
        trim_we = 1; trim_din = 7'h3F;
        @(negedge clk);
        trim_we = 0;
        measure(n);
        check("R7", "same-edge write uses old code", n, NOM + 12);
        go_to_sec(8'h00); measure(n);
        check("R7", "same-edge write applied later", n, NOM + 124);

        cur_req = "R10";
        go_to_sec(8'h10); measure(n);
        check("R10", "second 10 untrimmed", n, NOM);

        cur_req = "R8";
        go_to_sec(8'h59); measure(n);
        check("R2", "second 59 untrimmed", n, NOM);
        @(negedge clk);
        check("R8", "wrap 59 to 00", int'(sec_bcd), 0);
        check("R9", "tick low after wrap", int'(sec_tick), 0);

        repeat (10) @(negedge clk);
        summary();
    end
endmodule